// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns one instruction-fetch virtual address per request into a physical address, an uncacheable flag and a fault code. It sits between the fetch unit and the translation buffer. The buffer has already been searched, so the block takes its verdict (hit, physical page number, per-mode read-enable mask) as inputs and stores no translations of its own. Every result is registered and appears one cycle after the request strobe.

It handles several paths. A firmware program counter skips translation altogether. A physical-mode flag passes the address through unchanged. A kernel-only direct-mapped window, the superpage, maps virtual to physical with sign extension of physical bit 40. All other fetches take the page-table path through the buffer's result. After translation the physical address is checked against the 44-bit implemented range. It is then checked for the uncached region and for the internal-register window. Three saturating counters record hits, misses and access violations.

Top module: `ifx_xlat`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_valid is 0 and all three counters read 0.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and the result fields belong to that request.
- R3: When req_pc bit 0 is 1, the result is req_va bits 43:2 with bits 1:0 cleared, fault code 0 (none) and uncacheable 0, even if bit 43 is set. This path wins over every other path and counts one hit.
- R4: With req_pc bit 0 clear and req_phys 1, the physical address equals req_va with no translation and no counter change. Only the range check (R10) and the uncached handling (R11) then apply.
- R5: Otherwise, if req_va bits 63:42 are not all equal, the fault code is 1 (access violation) and the access-violation count rises. This happens whatever the translation buffer reports.
- R6: A valid address with req_va bits 47:41 equal to 7'h7e is a superpage access. When req_mode is not 0 (kernel), it gives fault code 1. The modes are encoded as kernel 0, executive 1, supervisor 2, user 3.
- R7: A kernel superpage access takes req_va bits 43:0. If bit 40 of that is 1, bits 43:40 are forced to 1; otherwise bits 43:40 are cleared. The translation buffer is ignored, and no counter moves.
- R8: On the page-table path, tlb_hit 0 gives fault code 2 (page miss) and increments the miss count. Any nonzero fault code drives rsp_pa to 0.
- R9: On a hit, the address is {tlb_ppn, req_va bits 12:2, 2'b00}. If bit req_mode of tlb_rd_en is 0, the result is fault code 1 and one access-violation count; otherwise one hit count.
- R10: A fault-free physical address with any bit above 43 set gives fault code 3 (machine check).
- R11: A fault-free address with bit 43 set is flagged uncacheable and has bits 42:35 cleared. If instead its bits 43:20 are all 1, it gives fault code 4 (unimplemented) and no uncacheable flag.
- R12: Each counter is CNT_W bits wide, rises by at most one per request, and holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Fetch virtual address |
| req_pc | input | 64 | Program counter; bit 0 marks firmware mode |
| req_phys | input | 1 | Physical-mode request |
| req_mode | input | 2 | Current processor mode |
| tlb_hit | input | 1 | Translation buffer hit |
| tlb_ppn | input | 31 | Physical page number from the buffer |
| tlb_rd_en | input | 4 | Read-enable mask, one bit per mode |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Uncacheable access |
| rsp_fault | output | 3 | Fault code |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |
| acv_cnt | output | CNT_W | Saturating access-violation count |

## Verification
Two functions land on the same response when a kernel superpage address has bit 40 set. The sign extension then sets bit 43, so the uncached-region clearing must act on the already extended address in the same cycle. The bench sends such an address and expects bits 42:40 to be cleared again while bit 43 stays set. It also sends one that reaches the internal-register window, where the expected result is the unimplemented fault with a zero address. A second overlap comes from long runs of back-to-back firmware fetches: the hit counter reaches saturation while results stream every cycle, and the final counts are compared with expected values kept by the bench.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
    localparam int VA_BITS   = 64;
    localparam int PA_W      = 44;
    localparam int VA_SIG    = 43;
    localparam int PG_W      = 13;
    localparam int PPN_W     = PA_W - PG_W;
    localparam int SP_HI     = 47;
    localparam int SP_LO     = 41;
    localparam logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e;
    localparam int SP_EXT    = 40;
    localparam int UC_BIT    = 43;
    localparam int UC_CLR_HI = 42;
    localparam int UC_CLR_LO = 35;
    localparam int IPR_LO    = 20;
    localparam int N_CNT     = 3;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ACV   = 3'd1,
        FLT_MISS  = 3'd2,
        FLT_MCHK  = 3'd3,
        FLT_UNIMP = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HIT  = 2'd1,
        EV_MISS = 2'd2,
        EV_ACV  = 2'd3
    } event_e;

    typedef struct packed {
        logic [VA_BITS-1:0] pa;
        fault_e             fault;
        logic               skip_post;
        event_e             ev;
    } route_t;

    function automatic logic va_canonical(input logic [VA_BITS-1:0] va);
        return (&va[VA_BITS-1:VA_SIG-1]) | ~(|va[VA_BITS-1:VA_SIG-1]);
    endfunction

    function automatic logic va_superpage(input logic [VA_BITS-1:0] va);
        return va[SP_HI:SP_LO] == SP_TAG;
    endfunction
endpackage

// File: rtl/ifx_route.sv
module ifx_route
    import ifx_pkg::*;
(
    input  logic [VA_BITS-1:0] va,
    input  logic [VA_BITS-1:0] pc,
    input  logic               phys,
    input  logic [1:0]         mode,
    input  logic               tlb_hit,
    input  logic [PPN_W-1:0]   tlb_ppn,
    input  logic [3:0]         tlb_rd_en,
    output route_t             rt
);
    localparam int HI_PAD = VA_BITS - PA_W;
    logic [PA_W-1:0] sp_pa;

    always_comb begin
        sp_pa = va[PA_W-1:0];
        if (sp_pa[SP_EXT])
            sp_pa[PA_W-1:SP_EXT] = '1;
        else
            sp_pa[PA_W-1:SP_EXT] = '0;
    end

    always_comb begin
        rt           = '0;
        rt.fault     = FLT_NONE;
        rt.ev        = EV_NONE;
        rt.skip_post = 1'b0;
        if (pc[0]) begin
            // firmware fetch: strip marker bits, keep implemented range
            rt.pa        = {{HI_PAD{1'b0}}, va[PA_W-1:2], 2'b00};
            rt.skip_post = 1'b1;
            rt.ev        = EV_HIT;
        end else if (phys) begin
            rt.pa = va;
        end else if (!va_canonical(va)) begin
            rt.fault = FLT_ACV;
            rt.ev    = EV_ACV;
        end else if (va_superpage(va)) begin
            if (mode != MODE_KERN) begin
                rt.fault = FLT_ACV;
                rt.ev    = EV_ACV;
            end else begin
                rt.pa = {{HI_PAD{1'b0}}, sp_pa};
            end
        end else if (!tlb_hit) begin
            rt.fault = FLT_MISS;
            rt.ev    = EV_MISS;
        end else begin
            rt.pa = {{HI_PAD{1'b0}}, tlb_ppn, va[PG_W-1:2], 2'b00};
            if (!tlb_rd_en[mode]) begin
                rt.fault = FLT_ACV;
                rt.ev    = EV_ACV;
            end else begin
                rt.ev = EV_HIT;
            end
        end
    end
endmodule

// File: rtl/ifx_post.sv
module ifx_post
    import ifx_pkg::*;
(
    input  route_t          rt,
    output logic [PA_W-1:0] pa,
    output logic            uncached,
    output fault_e          fault
);
    always_comb begin
        pa       = '0;
        uncached = 1'b0;
        fault    = FLT_NONE;
        if (rt.fault != FLT_NONE) begin
            fault = rt.fault;
        end else if (rt.skip_post) begin
            pa = rt.pa[PA_W-1:0];
        end else if (|rt.pa[VA_BITS-1:PA_W]) begin
            fault = FLT_MCHK;
        end else if (rt.pa[UC_BIT]) begin
            if (&rt.pa[PA_W-1:IPR_LO]) begin
                fault = FLT_UNIMP;
            end else begin
                uncached = 1'b1;
                pa       = rt.pa[PA_W-1:0];
                pa[UC_CLR_HI:UC_CLR_LO] = '0;
            end
        end else begin
            pa = rt.pa[PA_W-1:0];
        end
    end
endmodule

// File: rtl/ifx_sat_cnt.sv
module ifx_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && !(&cnt))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ifx_xlat.sv
module ifx_xlat
    import ifx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [63:0]      req_va,
    input  logic [63:0]      req_pc,
    input  logic             req_phys,
    input  logic [1:0]       req_mode,
    input  logic             tlb_hit,
    input  logic [30:0]      tlb_ppn,
    input  logic [3:0]       tlb_rd_en,
    output logic             rsp_valid,
    output logic [43:0]      rsp_pa,
    output logic             rsp_uncached,
    output logic [2:0]       rsp_fault,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [CNT_W-1:0] acv_cnt
);
    route_t          rt;
    logic [PA_W-1:0] post_pa;
    logic            post_uc;
    fault_e          post_flt;
    logic [N_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt_q [N_CNT];

    ifx_route route_i (
        .va        (req_va),
        .pc        (req_pc),
        .phys      (req_phys),
        .mode      (req_mode),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .tlb_rd_en (tlb_rd_en),
        .rt        (rt)
    );

    ifx_post post_i (
        .rt       (rt),
        .pa       (post_pa),
        .uncached (post_uc),
        .fault    (post_flt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= post_pa;
                rsp_uncached <= post_uc;
                rsp_fault    <= post_flt;
            end
        end
    end

    always_comb begin
        inc[0] = req_valid && (rt.ev == EV_HIT);
        inc[1] = req_valid && (rt.ev == EV_MISS);
        inc[2] = req_valid && (rt.ev == EV_ACV);
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        ifx_sat_cnt #(.W(CNT_W)) cnt_i (
            .clk (clk),
            .rst (rst),
            .inc (inc[g]),
            .cnt (cnt_q[g])
        );
    end

    assign hit_cnt  = cnt_q[0];
    assign miss_cnt = cnt_q[1];
    assign acv_cnt  = cnt_q[2];
endmodule

// File: rtl/ifx_xlat_chk.sv
module ifx_xlat_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [63:0]      req_pc,
    input logic             rsp_valid,
    input logic [43:0]      rsp_pa,
    input logic             rsp_uncached,
    input logic [2:0]       rsp_fault,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [CNT_W-1:0] acv_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R3
    firmware_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_pc[0]) |=> (rsp_fault == 3'd0 && !rsp_uncached));
    // R8
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == 44'd0));
    // R11
    uncached_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_uncached) |-> (rsp_pa[43] && rsp_pa[42:35] == 8'd0 && rsp_fault == 3'd0));
    // R12
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({hit_cnt != $past(hit_cnt), miss_cnt != $past(miss_cnt),
                    acv_cnt != $past(acv_cnt)}) <= 1);
    // R12
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(hit_cnt) && $stable(miss_cnt) && $stable(acv_cnt)));
    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_cnt == CMAX) |=> (hit_cnt == CMAX));
endmodule

bind ifx_xlat ifx_xlat_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_pc       (req_pc),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_uncached (rsp_uncached),
    .rsp_fault    (rsp_fault),
    .hit_cnt      (hit_cnt),
    .miss_cnt     (miss_cnt),
    .acv_cnt      (acv_cnt)
);

// File: tb/ifx_xlat_tb_top.sv
module ifx_xlat_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [63:0]      req_va = '0;
    logic [63:0]      req_pc = '0;
    logic             req_phys = 1'b0;
    logic [1:0]       req_mode = '0;
    logic             tlb_hit = 1'b0;
    logic [30:0]      tlb_ppn = '0;
    logic [3:0]       tlb_rd_en = '0;
    logic             rsp_valid;
    logic [43:0]      rsp_pa;
    logic             rsp_uncached;
    logic [2:0]       rsp_fault;
    logic [CNT_W-1:0] hit_cnt, miss_cnt, acv_cnt;

    typedef struct {
        string       tag;
        logic [43:0] pa;
        logic        uc;
        logic [2:0]  flt;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    int   e_hit  = 0;
    int   e_miss = 0;
    int   e_acv  = 0;
    bit   done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifx_xlat #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_pc(req_pc), .req_phys(req_phys), .req_mode(req_mode),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .rsp_fault(rsp_fault), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
        .acv_cnt(acv_cnt)
    );

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // ev: 0 none, 1 hit, 2 miss, 3 access violation
    task automatic send(input string tag, input logic [63:0] va,
                        input logic [63:0] pc, input logic phys,
                        input logic [1:0] mode, input logic hit,
                        input logic [30:0] ppn, input logic [3:0] rd,
                        input logic [43:0] epa, input logic euc,
                        input logic [2:0] eflt, input int ev);
        exp_t e;
        @(negedge clk);
        req_va = va; req_pc = pc; req_phys = phys; req_mode = mode;
        tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = rd; req_valid = 1'b1;
        e.tag = tag; e.pa = epa; e.uc = euc; e.flt = eflt;
        exp_q.push_back(e);
        if (ev == 1) e_hit = sat(e_hit);
        if (ev == 2) e_miss = sat(e_miss);
        if (ev == 3) e_acv = sat(e_acv);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic check_cnt(input string tag);
        n_run++;
        if (hit_cnt != e_hit[CNT_W-1:0] || miss_cnt != e_miss[CNT_W-1:0] ||
            acv_cnt != e_acv[CNT_W-1:0]) begin
            n_fail++;
            $display("FAIL %s counters actual hit=%0d miss=%0d acv=%0d expected hit=%0d miss=%0d acv=%0d",
                     tag, hit_cnt, miss_cnt, acv_cnt, e_hit, e_miss, e_acv);
        end
    endtask

    // monitor: compare each response against the oldest expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected response actual pa=%h expected none", rsp_pa);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_pa !== e.pa || rsp_uncached !== e.uc || rsp_fault !== e.flt) begin
                    n_fail++;
                    $display("FAIL %s actual pa=%h uc=%0b flt=%0d expected pa=%h uc=%0b flt=%0d",
                             e.tag, rsp_pa, rsp_uncached, rsp_fault, e.pa, e.uc, e.flt);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 rsp_valid in reset actual %b expected 0", rsp_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        check_cnt("R1");

        // R3 firmware wins over a bad VA; bit 43 left without uncached flag
        send("R3", 64'h0000_0F00_0000_0007, 64'h1, 1'b1, 2'd3, 1'b0, '0, '0,
             44'hF00_0000_0004, 1'b0, 3'd0, 1);
        // R4 physical pass-through
        send("R4", 64'h0000_0123_4567_89A0, 64'h0, 1'b1, 2'd3, 1'b0, '0, '0,
             44'h123_4567_89A0, 1'b0, 3'd0, 0);
        // R10 physical address beyond implemented range
        send("R10", 64'h0000_1000_0000_0000, 64'h0, 1'b1, 2'd0, 1'b0, '0, '0,
             44'h0, 1'b0, 3'd3, 0);
        // R11 physical uncached: bits 42:35 cleared
        send("R11", 64'h0000_0FFF_0000_0100, 64'h0, 1'b1, 2'd0, 1'b0, '0, '0,
             44'h807_0000_0100, 1'b1, 3'd0, 0);
        // R5 non-canonical VA despite a buffer hit
        send("R5", 64'h0000_0400_0000_0000, 64'h0, 1'b0, 2'd0, 1'b1, 31'h1, 4'hF,
             44'h0, 1'b0, 3'd1, 3);
        // R6 superpage from user mode
        send("R6", 64'hFFFF_FC00_0000_1234, 64'h0, 1'b0, 2'd3, 1'b1, 31'h1, 4'hF,
             44'h0, 1'b0, 3'd1, 3);
        // R7 kernel superpage, bit 40 clear, buffer miss ignored
        send("R7", 64'hFFFF_FC00_0000_1234, 64'h0, 1'b0, 2'd0, 1'b0, '0, '0,
             44'h000_0000_1234, 1'b0, 3'd0, 0);
        // R7 bit 40 set extends into bit 43, then R11 clears 42:35
        send("R7", 64'hFFFF_FD00_0012_3456, 64'h0, 1'b0, 2'd0, 1'b0, '0, '0,
             44'h800_0012_3456, 1'b1, 3'd0, 0);
        // R11 superpage result inside the internal-register window
        send("R11", 64'hFFFF_FDFF_FFF0_0000, 64'h0, 1'b0, 2'd0, 1'b0, '0, '0,
             44'h0, 1'b0, 3'd4, 0);
        // R8 page miss
        send("R8", 64'h0000_0000_0040_2468, 64'h0, 1'b0, 2'd0, 1'b0, '0, 4'hF,
             44'h0, 1'b0, 3'd2, 2);
        // R9 kernel hit
        send("R9", 64'h0000_0000_0040_246B, 64'h0, 1'b0, 2'd0, 1'b1, 31'h0001_2345, 4'b0001,
             44'h000_2468_A468, 1'b0, 3'd0, 1);
        // R9 user without its read enable
        send("R9", 64'h0000_0000_0040_246B, 64'h0, 1'b0, 2'd3, 1'b1, 31'h0001_2345, 4'b0111,
             44'h0, 1'b0, 3'd1, 3);
        // R9 user with its read enable only
        send("R9", 64'h0000_0000_0040_246B, 64'h0, 1'b0, 2'd3, 1'b1, 31'h0001_2345, 4'b1000,
             44'h000_2468_A468, 1'b0, 3'd0, 1);
        // R11 hit whose page lands in the uncached region
        send("R11", 64'h0000_0000_0040_246B, 64'h0, 1'b0, 2'd2, 1'b1, 31'h4000_0001, 4'b0100,
             44'h800_0000_2468, 1'b1, 3'd0, 1);
        idle(2);
        check_cnt("R12 after mixed traffic");

        // R12 back-to-back firmware fetches drive the hit counter to saturation
        for (int i = 0; i < 260; i++) begin
            logic [63:0] va;
            va = 64'h0000_0000_0010_0000 + 64'(i * 4) + 64'd3;
            send("R12", va, 64'h3, 1'b0, 2'd3, 1'b0, '0, '0,
                 va[43:0] & ~44'h3, 1'b0, 3'd0, 1);
        end
        idle(2);
        check_cnt("R12 saturation");

        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing responses actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule